// File: doc/BRIEF.md
# Memory-Mapped Address Select and Decode

This block sits between the address sources of a small 8-bit processor and its memory and I/O. A 2-bit select picks one of four 8-bit sources as the memory address:

- the program-load address,
- the program counter,
- the memory address register,
- the index register.

The chosen address is compared against the topmost location, 0xFF, which is reserved for a single external I/O port. Two complementary active-low selects then route the access either to RAM or to that port. The selects are combined with the read and write strobes to form the port and RAM enables.

The block owns the data-bus driver, an 8-bit tri-state stage with an active-low enable. During an I/O read it puts the external input on the bus. During a write it puts the processor's write data on the bus. At all other times it leaves the bus at high impedance so that RAM or another agent can drive it. An I/O write loads the bus value into an output-port register at the clock edge. A read and a write requested together are treated as a conflict: no enable is given and an error flag is raised. Everything except the output-port register is combinational.

Top module: `mmio_addr_path`

## Requirements
- R1: `mem_addr` follows `addr_sel` in the same cycle: 00 selects `load_addr`, 01 selects `pc_val`, 10 selects `mar_val`, 11 selects `idx_val`.
- R2: When `mem_addr` is 0xFF, `io_sel_n` is 0 and `ram_sel_n` is 1.
- R3: When `mem_addr` is not 0xFF, `ram_sel_n` is 0 and `io_sel_n` is 1.
- R4: With `mem_addr` 0xFF, `rd` 1 and `wr` 0, `in_en_n` is 0 and `data_bus` carries `ext_in`. Otherwise `in_en_n` is 1.
- R5: With `mem_addr` 0xFF, `wr` 1 and `rd` 0, `out_en_n` is 0, and at the next rising clock edge `out_port` takes the value of `wr_data`. Otherwise `out_port` holds its value.
- R6: `ram_rd_n` is 0 only for `rd` 1, `wr` 0 at an address other than 0xFF. `ram_wr_n` is 0 only for `wr` 1, `rd` 0 at an address other than 0xFF.
- R7: With `wr` 1 and `rd` 0, `data_bus` carries `wr_data` at any address. With neither strobe, or on a RAM read, `data_bus` is high impedance.
- R8: With `rd` and `wr` both 1, `rw_err` is 1, the four enables are 1, `data_bus` is high impedance and `out_port` does not change. Otherwise `rw_err` is 0.
- R9: A rising edge with `rst_n` low clears `out_port` to 0x00, and no I/O write is captured at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output-port register |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel | input | 2 | Address source select |
| load_addr | input | 8 | Program-load address source |
| pc_val | input | 8 | Program counter source |
| mar_val | input | 8 | Memory address register source |
| idx_val | input | 8 | Index register source |
| rd | input | 1 | Memory read strobe, active high |
| wr | input | 1 | Memory write strobe, active high |
| ext_in | input | 8 | External input port value |
| wr_data | input | 8 | Processor data for writes |
| mem_addr | output | 8 | Selected memory address |
| io_sel_n | output | 1 | I/O port select, active low |
| ram_sel_n | output | 1 | RAM select, active low |
| in_en_n | output | 1 | Input port enable, active low |
| out_en_n | output | 1 | Output port enable, active low |
| ram_rd_n | output | 1 | RAM read enable, active low |
| ram_wr_n | output | 1 | RAM write enable, active low |
| rw_err | output | 1 | Read/write conflict flag |
| data_bus | output | 8 | Tri-state data bus |
| out_port | output | 8 | Output port register |

## Verification
The address, selects, enables, error flag and bus are due in the same cycle that their inputs change. The output port is due one rising edge after an I/O write or a reset cycle. The driver applies each vector on the falling edge and queues the expected values. The monitor compares them a quarter period later, before the next rising edge. For `out_port`, the expected value is therefore the register content left by all earlier edges, and the model is advanced only after the vector has been queued.

// File: rtl/mmio_pkg.sv
// Shared types for the memory-mapped address path.
// Assumes an 8-bit address space whose top location is the I/O port.
package mmio_pkg;
    typedef enum logic [1:0] {
        SRC_LOAD = 2'b00,
        SRC_PC   = 2'b01,
        SRC_MAR  = 2'b10,
        SRC_IDX  = 2'b11
    } addr_src_e;
endpackage

// File: rtl/mmio_addr_mux.sv
// Four-way address source selector.
// Assumes every source has the same width AW.
module mmio_addr_mux
    import mmio_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [1:0]    sel,
    input  logic [AW-1:0] src_load,
    input  logic [AW-1:0] src_pc,
    input  logic [AW-1:0] src_mar,
    input  logic [AW-1:0] src_idx,
    output logic [AW-1:0] addr
);
    // Pick the address source named by the select code.
    always_comb begin
        unique case (addr_src_e'(sel))
            SRC_LOAD: addr = src_load;
            SRC_PC:   addr = src_pc;
            SRC_MAR:  addr = src_mar;
            default:  addr = src_idx;
        endcase
    end
endmodule

// File: rtl/mmio_decode.sv
// Splits an access between RAM and the single I/O location and gates the strobes.
// Assumes strobes are active high; every output enable is active low.
module mmio_decode #(
    parameter int            AW      = 8,
    parameter logic [AW-1:0] IO_ADDR = '1
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output logic          io_sel_n,
    output logic          ram_sel_n,
    output logic          in_en_n,
    output logic          out_en_n,
    output logic          ram_rd_n,
    output logic          ram_wr_n,
    output logic          wr_drv,
    output logic          conflict
);
    logic io_hit;
    logic rd_only;
    logic wr_only;

    // Qualify the strobes and detect the reserved address.
    always_comb begin
        io_hit   = (addr == IO_ADDR);
        conflict = rd & wr;
        rd_only  = rd & ~wr;
        wr_only  = wr & ~rd;
    end

    // Drive the complementary selects and the gated enables.
    always_comb begin
        io_sel_n  = ~io_hit;
        ram_sel_n = io_hit;
        in_en_n   = ~(io_hit & rd_only);
        out_en_n  = ~(io_hit & wr_only);
        ram_rd_n  = ~(~io_hit & rd_only);
        ram_wr_n  = ~(~io_hit & wr_only);
        wr_drv    = wr_only;
    end
endmodule

// File: rtl/mmio_tribuf.sv
// Tri-state bus driver with an active-low enable.
// Assumes the enable is high whenever another agent owns the bus.
module mmio_tribuf #(
    parameter int DW = 8
) (
    input  logic          oe_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    // Drive the data when enabled, otherwise float.
    assign dout = oe_n ? {DW{1'bz}} : din;
endmodule

// File: rtl/mmio_out_reg.sv
// Output-port register, loaded from the bus on an I/O write.
// Assumes a synchronous active-low reset.
module mmio_out_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);
    // Clear on reset, otherwise load on an enabled write.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (!load_n) q <= din;
    end
endmodule

// File: rtl/mmio_addr_path.sv
// Address selection, RAM/I/O decode, bus driver and output port.
// Assumes rd/wr are active high; only the output port is clocked.
module mmio_addr_path #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr_sel,
    input  logic [AW-1:0] load_addr,
    input  logic [AW-1:0] pc_val,
    input  logic [AW-1:0] mar_val,
    input  logic [AW-1:0] idx_val,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] ext_in,
    input  logic [DW-1:0] wr_data,
    output logic [AW-1:0] mem_addr,
    output logic          io_sel_n,
    output logic          ram_sel_n,
    output logic          in_en_n,
    output logic          out_en_n,
    output logic          ram_rd_n,
    output logic          ram_wr_n,
    output logic          rw_err,
    output logic [DW-1:0] data_bus,
    output logic [DW-1:0] out_port
);
    localparam logic [AW-1:0] IO_ADDR = {AW{1'b1}};

    logic          wr_drv;
    logic          bus_oe_n;
    logic [DW-1:0] bus_src;
    logic [DW-1:0] bus_int;

    mmio_addr_mux #(.AW(AW)) u_mux (
        .sel      (addr_sel),
        .src_load (load_addr),
        .src_pc   (pc_val),
        .src_mar  (mar_val),
        .src_idx  (idx_val),
        .addr     (mem_addr)
    );

    mmio_decode #(.AW(AW), .IO_ADDR(IO_ADDR)) u_dec (
        .addr      (mem_addr),
        .rd        (rd),
        .wr        (wr),
        .io_sel_n  (io_sel_n),
        .ram_sel_n (ram_sel_n),
        .in_en_n   (in_en_n),
        .out_en_n  (out_en_n),
        .ram_rd_n  (ram_rd_n),
        .ram_wr_n  (ram_wr_n),
        .wr_drv    (wr_drv),
        .conflict  (rw_err)
    );

    // Choose what the bus driver sends: port input on I/O read, write data otherwise.
    always_comb begin
        bus_src  = in_en_n ? wr_data : ext_in;
        bus_oe_n = in_en_n & ~wr_drv;
    end

    mmio_tribuf #(.DW(DW)) u_buf (
        .oe_n (bus_oe_n),
        .din  (bus_src),
        .dout (bus_int)
    );

    assign data_bus = bus_int;

    mmio_out_reg #(.DW(DW)) u_oreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (out_en_n),
        .din    (bus_int),
        .q      (out_port)
    );
endmodule

// File: rtl/mmio_addr_path_chk.sv
// Property checker bound to the address path.
module mmio_addr_path_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          rd,
    input logic          wr,
    input logic [DW-1:0] ext_in,
    input logic [DW-1:0] wr_data,
    input logic          io_sel_n,
    input logic          ram_sel_n,
    input logic          in_en_n,
    input logic          out_en_n,
    input logic          ram_rd_n,
    input logic          ram_wr_n,
    input logic          rw_err,
    input logic [DW-1:0] data_bus,
    input logic [DW-1:0] out_port
);
    // R2
    sel_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr == {AW{1'b1}}) |-> (!io_sel_n && ram_sel_n));
    // R3
    sel_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != {AW{1'b1}}) |-> (io_sel_n && !ram_sel_n));
    // R6
    one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~in_en_n, ~out_en_n, ~ram_rd_n, ~ram_wr_n}));
    // R4
    in_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en_n |-> (data_bus === ext_in));
    // R5
    port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_n |=> (out_port == $past(wr_data)));
    // R5
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |=> $stable(out_port));
    // R8
    conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wr) |-> (rw_err && in_en_n && out_en_n && ram_rd_n && ram_wr_n));
endmodule

bind mmio_addr_path mmio_addr_path_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_mmio_addr_path.sv
module sim_mmio_addr_path;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string      tag;
        logic [7:0] addr;
        logic       io_n, ram_n, in_n, out_n, rrd_n, rwr_n, err;
        logic [7:0] bus;
        logic [7:0] port;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr_sel = '0;
    logic [7:0] load_addr = '0, pc_val = '0, mar_val = '0, idx_val = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] ext_in = '0, wr_data = '0;
    logic [7:0] mem_addr, data_bus, out_port;
    logic       io_sel_n, ram_sel_n, in_en_n, out_en_n, ram_rd_n, ram_wr_n, rw_err;

    exp_t       q[$];
    logic [7:0] model_port = 8'h00;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_addr_path u0 (.*);

    // Driver: apply one vector on the falling edge and queue its expected results.
    task automatic apply(input string tag, input logic rn, input logic [1:0] s,
                         input logic [7:0] l, input logic [7:0] p, input logic [7:0] m,
                         input logic [7:0] x, input logic r, input logic w,
                         input logic [7:0] ei, input logic [7:0] wd);
        exp_t e;
        logic io;
        @(negedge clk);
        rst_n = rn; addr_sel = s; load_addr = l; pc_val = p; mar_val = m; idx_val = x;
        rd = r; wr = w; ext_in = ei; wr_data = wd;
        e.tag  = tag;
        e.addr = (s == 2'b00) ? l : (s == 2'b01) ? p : (s == 2'b10) ? m : x;
        io     = (e.addr == 8'hFF);
        e.io_n  = !io;
        e.ram_n = io;
        e.err   = r & w;
        e.in_n  = !(io & r & !w);
        e.out_n = !(io & w & !r);
        e.rrd_n = !(!io & r & !w);
        e.rwr_n = !(!io & w & !r);
        e.bus   = !e.in_n ? ei : (w & !r) ? wd : 8'hzz;
        e.port  = model_port;
        q.push_back(e);
        if (!rn) model_port = 8'h00;
        else if (!e.out_n) model_port = wd;
    endtask

    // Monitor: compare queued expectations a quarter period after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (mem_addr !== e.addr || io_sel_n !== e.io_n || ram_sel_n !== e.ram_n ||
                    in_en_n !== e.in_n || out_en_n !== e.out_n || ram_rd_n !== e.rrd_n ||
                    ram_wr_n !== e.rwr_n || rw_err !== e.err || data_bus !== e.bus ||
                    out_port !== e.port) begin
                    n_bad++;
                    $display("FAIL %s: got addr=%h io=%b ram=%b in=%b out=%b rrd=%b rwr=%b err=%b bus=%h port=%h exp addr=%h io=%b ram=%b in=%b out=%b rrd=%b rwr=%b err=%b bus=%h port=%h",
                        e.tag, mem_addr, io_sel_n, ram_sel_n, in_en_n, out_en_n, ram_rd_n,
                        ram_wr_n, rw_err, data_bus, out_port, e.addr, e.io_n, e.ram_n,
                        e.in_n, e.out_n, e.rrd_n, e.rwr_n, e.err, e.bus, e.port);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD*5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        // R9 reset state and I/O write ignored during reset
        apply("R9", 1'b0, 2'b00, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'hAA);
        apply("R9", 1'b0, 2'b00, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
        // R1 each source, R7 bus floats when idle
        apply("R1", 1'b1, 2'b00, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0, 1'b0, 8'h00, 8'h00);
        apply("R1", 1'b1, 2'b01, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0, 1'b0, 8'h00, 8'h00);
        apply("R1", 1'b1, 2'b10, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0, 1'b0, 8'h00, 8'h00);
        apply("R1", 1'b1, 2'b11, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0, 1'b0, 8'h00, 8'h00);
        // R3 / R6 RAM read at address 0, bus floats (R7)
        apply("R6", 1'b1, 2'b01, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'h99, 8'h00);
        // R6 / R7 RAM write at 0xFE, bus carries write data
        apply("R7", 1'b1, 2'b10, 8'h00, 8'h00, 8'hFE, 8'h00, 1'b0, 1'b1, 8'h00, 8'h5C);
        // R2 top address via load source, idle
        apply("R2", 1'b1, 2'b00, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
        // R4 I/O read via index register
        apply("R4", 1'b1, 2'b11, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0, 8'h5A, 8'h00);
        // R5 I/O write via MAR, then observe the port
        apply("R5", 1'b1, 2'b10, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 8'hC3);
        apply("R5", 1'b1, 2'b00, 8'h40, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
        // R5 RAM write does not touch the port
        apply("R5", 1'b1, 2'b01, 8'h00, 8'h80, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h0F);
        apply("R5", 1'b1, 2'b01, 8'h00, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
        // R8 conflict at top address and at a RAM address; port unchanged
        apply("R8", 1'b1, 2'b11, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1, 8'h66, 8'h77);
        apply("R8", 1'b1, 2'b00, 8'h10, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 8'h66, 8'h77);
        apply("R8", 1'b1, 2'b00, 8'h10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
        // R5 second I/O write, then R9 reset clears the port
        apply("R5", 1'b1, 2'b01, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h3C);
        apply("R9", 1'b0, 2'b00, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
        apply("R9", 1'b1, 2'b00, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule